// File: doc/BRIEF.md
# Transmit Queue Enqueue Controller

This block decides when frames that a host has built in a transmit buffer are handed to the transmitter. The transmit path reports each finished frame build with a one-cycle prepare pulse, and the block counts these pending frames. Each frame released to the transmitter is marked by a one-cycle enqueue strobe. The host chooses how frames are released by writing a three-bit command word. In single-frame mode, one command releases one frame, and the command bit stays set until the transmitter reports that frame done. In automatic mode, every pending frame is released without further commands.

A third command bit arms a one-shot free-space watch. It compares the free byte count that the transmit path reports against a byte amount requested by the host. When the free count reaches that amount, the watch disarms itself and latches an interrupt status bit. That bit stays set until the host clears it.

Command word bit positions are bit 0 single-frame, bit 1 free-space watch, and bit 2 automatic. The same positions are used for writes and for the read-back on `cmd_rd`.

Top module: `txq_enq_ctrl`

## Requirements
- R1: After reset, `cmd_rd` is 000, `enq_strobe` is 0 and `irq` is 0. No frame is pending.
- R2: A write with bit 0 set and bit 2 clear, while automatic mode is off, sets the single-frame bit. While the bit is set and at least one frame is pending, exactly one `enq_strobe` pulse is issued. If no frame is pending, the pulse waits until one is.
- R3: The single-frame bit clears on a `frame_done` pulse only after its strobe has been issued. A `frame_done` pulse before the strobe is ignored, and writing 0 to bit 0 does not cancel a pending request.
- R4: While automatic mode (bit 2) is set, `enq_strobe` is high in every cycle in which the pending count is nonzero. Bit 2 follows each command write.
- R5: The single-frame and automatic bits are never both set. A single-frame request is ignored (bit 0 reads 0, no strobe) when automatic mode is on or bit 2 is set in the same write. A write that sets bit 2 while a single-frame request is outstanding leaves bit 2 at 0.
- R6: The pending count rises on each `frame_prep` pulse and falls on each `enq_strobe`. It saturates at 2^CNT_W-1, so with CNT_W=4, twenty prepares followed by automatic mode give exactly 15 strobes.
- R7: A write with bit 1 set arms the free-space watch (bit 1 reads 1). In the first cycle in which it is armed and `free_bytes >= req_bytes`, bit 1 clears and the interrupt status sets, visible on `irq` one clock later. A free count below the request leaves it armed.
- R8: The interrupt status stays set until `irq_clr` is pulsed. A new trigger in the same cycle as a clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 3 | Command word: bit0 single-frame, bit1 watch, bit2 automatic |
| irq_clr | input | 1 | Write-one clear of the interrupt status |
| req_bytes | input | FREE_W (12) | Free byte amount requested by the host |
| frame_prep | input | 1 | Pulse: one more frame built in the buffer |
| frame_done | input | 1 | Pulse: transmitter finished a frame |
| free_bytes | input | FREE_W (12) | Current free bytes in the transmit buffer |
| enq_strobe | output | 1 | Pulse: release one frame to the transmitter |
| cmd_rd | output | 3 | Read-back of the command bits |
| irq | output | 1 | Interrupt status (free-space reached) |

## Verification
The hardest state to reach from the ports is a full pending counter that receives another prepare pulse. The bench holds automatic mode off while it sends twenty prepare pulses, then turns automatic mode on and counts the strobe run that drains the counter. Two same-cycle collisions are also driven directly: a watch trigger together with an interrupt clear, and a `frame_done` pulse that arrives while a single-frame request still has no pending frame to release.

// File: rtl/txq_pkg.sv
// Package: shared command-word layout for the transmit enqueue controller.
// Assumes a three-bit command word; bit positions are fixed by the host map.
package txq_pkg;
    localparam int CMD_W   = 3;
    localparam int BIT_MAN = 0;   // single-frame enqueue
    localparam int BIT_MON = 1;   // free-space watch
    localparam int BIT_AUT = 2;   // automatic enqueue
endpackage

// File: rtl/txq_pend_cnt.sv
// Module: saturating count of frames built but not yet released.
// Assumes dec_i is only raised while the count is nonzero.
module txq_pend_cnt #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    output logic pend_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             inc_ok;

    // A prepare is accepted unless full with no release in the same cycle
    assign inc_ok = inc_i && ((cnt_q != CNT_MAX) || dec_i);

    // Update the pending count
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (inc_ok && !dec_i)
            cnt_q <= cnt_q + 1'b1;
        else if (dec_i && !inc_ok)
            cnt_q <= cnt_q - 1'b1;
    end

    assign pend_o = (cnt_q != '0);

    // R6: a release never happens with nothing pending
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (cnt_q != '0));
    // R6: a full counter with only a prepare stays full
    p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) && inc_i && !dec_i |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/txq_enq_mode.sv
// Module: single-frame and automatic release modes and the enqueue strobe.
// Assumes frame_done pulses refer to the frame last released.
module txq_enq_mode
    import txq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    input  logic             frame_done,
    input  logic             pend_i,
    output logic             man_o,
    output logic             aut_o,
    output logic             enq_o
);
    logic man_q, aut_q, sent_q;
    logic man_req;

    // Single-frame request is legal only with automatic mode off now and in the write
    assign man_req = wr_en && wr_data[BIT_MAN] && !wr_data[BIT_AUT] && !aut_q;

    // Strobe: automatic drains the count; single-frame releases one frame
    assign enq_o = pend_i && (aut_q || (man_q && !sent_q));

    // Automatic mode bit follows writes, blocked while a single-frame request is open
    always_ff @(posedge clk) begin
        if (!rst_n)
            aut_q <= 1'b0;
        else if (wr_en)
            aut_q <= wr_data[BIT_AUT] && !man_q;
    end

    // Single-frame bit: set by a legal request, cleared by done after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            man_q  <= 1'b0;
            sent_q <= 1'b0;
        end else if (man_q) begin
            if (sent_q && frame_done) begin
                man_q  <= 1'b0;
                sent_q <= 1'b0;
            end else if (enq_o) begin
                sent_q <= 1'b1;
            end
        end else if (man_req) begin
            man_q <= 1'b1;
        end
    end

    assign man_o = man_q;
    assign aut_o = aut_q;

    // R5: modes exclude each other
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(man_q && aut_q));
    // R2: only one strobe per single-frame request
    p_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        man_q && !aut_q && enq_o |=> !enq_o || !man_q);
    // R3: bit holds until done arrives after the strobe
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        man_q && !sent_q |=> man_q);
    // R4: automatic mode releases whenever something is pending
    p_auto_r4: assert property (@(posedge clk) disable iff (!rst_n)
        aut_q && pend_i |-> enq_o);
endmodule

// File: rtl/txq_mem_watch.sv
// Module: one-shot free-space watch with a sticky interrupt status.
// Assumes free_bytes and req_bytes are stable, synchronous values.
module txq_mem_watch #(
    parameter int FREE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              clr_i,
    input  logic [FREE_W-1:0] free_bytes,
    input  logic [FREE_W-1:0] req_bytes,
    output logic              mon_o,
    output logic              irq_o
);
    logic mon_q, irq_q, hit;

    assign hit = mon_q && (free_bytes >= req_bytes);

    // Watch bit: armed by a write, self-clears when the space is reached
    always_ff @(posedge clk) begin
        if (!rst_n)
            mon_q <= 1'b0;
        else if (hit)
            mon_q <= 1'b0;
        else if (arm_i)
            mon_q <= 1'b1;
    end

    // Interrupt status: set by a hit (wins over clear), cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (hit)
            irq_q <= 1'b1;
        else if (clr_i)
            irq_q <= 1'b0;
    end

    assign mon_o = mon_q;
    assign irq_o = irq_q;

    // R7: a hit disarms the watch and raises the status
    p_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mon_q && (free_bytes >= req_bytes) |=> !mon_q && irq_q);
    // R7: too little space keeps the watch armed
    p_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mon_q && (free_bytes < req_bytes) |=> mon_q);
    // R8: status is sticky without a clear
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !clr_i |=> irq_q);
endmodule

// File: rtl/txq_enq_ctrl.sv
// Module: top of the transmit enqueue controller. Joins the pending counter,
// the release-mode logic and the free-space watch; assembles the read-back word.
// Assumes all inputs are synchronous to clk.
module txq_enq_ctrl
    import txq_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int FREE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CMD_W-1:0]  wr_data,
    input  logic              irq_clr,
    input  logic [FREE_W-1:0] req_bytes,
    input  logic              frame_prep,
    input  logic              frame_done,
    input  logic [FREE_W-1:0] free_bytes,
    output logic              enq_strobe,
    output logic [CMD_W-1:0]  cmd_rd,
    output logic              irq
);
    logic pend, man, aut, mon, enq;

    txq_pend_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (frame_prep),
        .dec_i  (enq),
        .pend_o (pend)
    );

    txq_enq_mode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .frame_done (frame_done),
        .pend_i     (pend),
        .man_o      (man),
        .aut_o      (aut),
        .enq_o      (enq)
    );

    txq_mem_watch #(.FREE_W(FREE_W)) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (wr_en && wr_data[BIT_MON]),
        .clr_i      (irq_clr),
        .free_bytes (free_bytes),
        .req_bytes  (req_bytes),
        .mon_o      (mon),
        .irq_o      (irq)
    );

    // Read-back word in command-bit order
    always_comb begin
        cmd_rd          = '0;
        cmd_rd[BIT_MAN] = man;
        cmd_rd[BIT_MON] = mon;
        cmd_rd[BIT_AUT] = aut;
    end

    assign enq_strobe = enq;

    // R1: nothing is released in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !enq_strobe && (cmd_rd == '0) && !irq);
endmodule

// File: tb/txq_enq_ctrl_tb.sv
module txq_enq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_data = '0;
    logic        irq_clr = 1'b0;
    logic [11:0] req_bytes = '0;
    logic        frame_prep = 1'b0;
    logic        frame_done = 1'b0;
    logic [11:0] free_bytes = '0;
    logic        enq_strobe;
    logic [2:0]  cmd_rd;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done_run = 0;

    always #5 clk = ~clk;

    txq_enq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_clr(irq_clr), .req_bytes(req_bytes), .frame_prep(frame_prep),
        .frame_done(frame_done), .free_bytes(free_bytes),
        .enq_strobe(enq_strobe), .cmd_rd(cmd_rd), .irq(irq)
    );

    // Each row: expected outputs before the row's inputs, then the inputs
    typedef struct packed {
        logic        e_enq;
        logic [2:0]  e_cmd;
        logic        e_irq;
        logic        we;
        logic [2:0]  wd;
        logic        clr;
        logic        prep;
        logic        done;
        logic [11:0] free;
        logic [11:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 12'd0, 12'd0}, // R1 idle, prep
        '{1'b0, 3'b000, 1'b0, 1'b1, 3'b001, 1'b0, 1'b0, 1'b0, 12'd0, 12'd0}, // R2 request
        '{1'b1, 3'b001, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 12'd0, 12'd0}, // R2 strobe
        '{1'b0, 3'b001, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 12'd0, 12'd0}, // R2 no second
        '{1'b0, 3'b001, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 12'd0, 12'd0}, // R3 done
        '{1'b0, 3'b000, 1'b0, 1'b1, 3'b100, 1'b0, 1'b0, 1'b0, 12'd0, 12'd0}, // R3 cleared
        '{1'b1, 3'b100, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 12'd0, 12'd0}, // R4 auto
        '{1'b1, 3'b100, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 12'd0, 12'd0}, // R4 again
        '{1'b0, 3'b100, 1'b0, 1'b1, 3'b101, 1'b0, 1'b0, 1'b0, 12'd0, 12'd0}, // R5 ignored
        '{1'b0, 3'b100, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 12'd0, 12'd0}, // R5 check
        '{1'b1, 3'b100, 1'b0, 1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 12'd0, 12'd0}, // R4 off
        '{1'b0, 3'b000, 1'b0, 1'b1, 3'b010, 1'b0, 1'b0, 1'b0, 12'd5, 12'd8}, // R7 arm
        '{1'b0, 3'b010, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 12'd7, 12'd8}, // R7 short
        '{1'b0, 3'b010, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 12'd8, 12'd8}, // R7 reached
        '{1'b0, 3'b000, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 12'd0, 12'd0}, // R7 fired
        '{1'b0, 3'b000, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 12'd0, 12'd0}, // R8 clear
        '{1'b0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 12'd0, 12'd0}  // R8 cleared
    };

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b (enq,cmd,irq)", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_data = '0; irq_clr = 0; frame_prep = 0; frame_done = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        int n;
        do_reset();
        // R1: reset state
        chk("R1", {enq_strobe, cmd_rd, irq}, 5'b0_000_0);
        for (int i = 0; i < NV; i++) begin
            if (i > 0) @(negedge clk);
            chk($sformatf("R2-8 row%0d", i), {enq_strobe, cmd_rd, irq},
                {TBL[i].e_enq, TBL[i].e_cmd, TBL[i].e_irq});
            wr_en = TBL[i].we; wr_data = TBL[i].wd; irq_clr = TBL[i].clr;
            frame_prep = TBL[i].prep; frame_done = TBL[i].done;
            free_bytes = TBL[i].free; req_bytes = TBL[i].req;
        end
        @(negedge clk); idle(); free_bytes = '0; req_bytes = '0;

        // R6: saturation, 20 prepares then auto drains 15
        do_reset();
        for (int i = 0; i < 20; i++) begin
            frame_prep = 1; @(negedge clk);
        end
        frame_prep = 0; wr_en = 1; wr_data = 3'b100;
        @(negedge clk); idle();
        n = 0;
        for (int i = 0; i < 25; i++) begin
            if (enq_strobe) n++;
            @(negedge clk);
        end
        checks++;
        if (n != 15) begin fails++; $display("FAIL R6 actual=%0d expected=15 strobes", n); end

        // R3: request with nothing pending waits; early done ignored; write 0 no cancel
        do_reset();
        wr_en = 1; wr_data = 3'b001; @(negedge clk); idle();
        chk("R2 wait", {enq_strobe, cmd_rd, irq}, 5'b0_001_0);
        frame_done = 1; @(negedge clk); idle();
        chk("R3 early done", {enq_strobe, cmd_rd, irq}, 5'b0_001_0);
        wr_en = 1; wr_data = 3'b000; @(negedge clk); idle();
        chk("R3 write0", {enq_strobe, cmd_rd, irq}, 5'b0_001_0);
        frame_prep = 1; @(negedge clk); idle();
        chk("R2 late strobe", {enq_strobe, cmd_rd, irq}, 5'b1_001_0);
        // R5: auto write while request open is blocked
        wr_en = 1; wr_data = 3'b100; @(negedge clk); idle();
        chk("R5 auto blocked", {enq_strobe, cmd_rd, irq}, 5'b0_001_0);
        frame_done = 1; @(negedge clk); idle();
        chk("R3 cleared", {enq_strobe, cmd_rd, irq}, 5'b0_000_0);

        // R5: manual plus auto in one write, auto off before
        wr_en = 1; wr_data = 3'b101; @(negedge clk); idle();
        chk("R5 same write", {enq_strobe, cmd_rd, irq}, 5'b0_100_0);

        // R8: trigger and clear in the same cycle keeps status set
        do_reset();
        free_bytes = 12'd100; req_bytes = 12'd50;
        wr_en = 1; wr_data = 3'b010; @(negedge clk); idle();
        chk("R7 armed", {enq_strobe, cmd_rd, irq}, 5'b0_010_0);
        irq_clr = 1; @(negedge clk); idle();
        chk("R8 set wins", {enq_strobe, cmd_rd, irq}, 5'b0_000_1);
        repeat (3) @(negedge clk);
        chk("R8 sticky", {enq_strobe, cmd_rd, irq}, 5'b0_000_1);

        done_run = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_run) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule